// File: doc/BRIEF.md
# Compare-Driven Pin Action Unit

This block sits beside a free-running 16-bit timer count and serves eight compare channels. Each channel has a compare value, a mode-select bit that arms it for output compare, an override mask bit and a two-bit action code. When the count reaches a channel's compare value on an advancing tick, the channel's output latch is updated by its action code: toggle, clear, set, or nothing. The action code also decides whether the channel pin is driven by the latch or released.

Software sees four 8-bit registers on a small register port. Two hold the action codes, one holds the output-compare arming bits, and one holds the override mask. A separate 16-bit port loads the compare values. When a channel's mask bit is set, the block stops updating that channel's latch, stops driving its pin and exports the mask so that outside logic can take the pin over. Channels 7 and 0 also report when their pin is free for use as a counting input.

Top module: `cmp_pin_unit`

## Requirements
- R1: After reset the count, all four registers, all compare values and all latches are zero. `pinOe` and `maskOut` are zero and `pacFree` is 2'b11.
- R2: The count increases by one on each clock edge where `tickEn` is 1, wraps from 0xFFFF to 0x0000, and holds when `tickEn` is 0.
- R3: Register addresses are 0 for the action codes of channels 7..4, 1 for the action codes of channels 3..0, 2 for the output-compare arming bits (bit n is channel n) and 3 for the mask (bit n is channel n). Channel n's code sits at bits [2(n mod 4)+1 : 2(n mod 4)] of its action register, with the mode bit above the level bit. `regRdData` returns the addressed register at any time.
- R4: A compare event for channel n happens in a cycle where `tickEn` is 1, the count equals the channel's compare value and arming bit n is 1. The latch changes on the edge that ends that cycle.
- R5: On an event, code 2'b01 (mode 0, level 1) inverts the latch.
- R6: On an event, code 2'b10 (mode 1, level 0) makes the latch 0.
- R7: On an event, code 2'b11 (mode 1, level 1) makes the latch 1.
- R8: On an event, code 2'b00 leaves the latch unchanged.
- R9: A latch keeps its value in every cycle without an event for its channel.
- R10: `pinOe[n]` is 1 exactly when channel n's code is not 2'b00 and mask bit n is 0.
- R11: While mask bit n is 1, events leave latch n unchanged, and `maskOut[n]` shows the mask bit.
- R12: `pacFree[1]` (channel 7) and `pacFree[0]` (channel 0) are 1 when that channel's arming bit is 0, its code is 2'b00 and its mask bit is 0.
- R13: A register write or compare-value write in the same cycle as an event takes effect after that event. The event uses the code and compare value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the count and qualifies compare events |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Addressed register contents |
| cmpWrEn | input | 1 | Compare-value write strobe |
| cmpSel | input | 3 | Channel whose compare value is written |
| cmpData | input | 16 | Compare value to write |
| cntVal | output | 16 | Current count |
| pinOut | output | 8 | Output latches, bit n is channel n |
| pinOe | output | 8 | Pin drive enables |
| maskOut | output | 8 | Override mask state |
| pacFree | output | 2 | Pin free for counting input: bit 1 channel 7, bit 0 channel 0 |

## Verification
A compare event and a software write can land on the same clock edge. The write may change the firing channel's action code or its compare value. The bench runs the count up to a known compare value and, in the firing cycle, rewrites the code of a channel from clear to set. It also rewrites a compare value in a firing cycle. The latch must follow the old code and the old compare value. A per-clock reference model applies the event before the write, so random traffic that hits this overlap is judged the same way.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  localparam int CH_NUM = 8;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TGL = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RS_ACT_HI = 2'd0,
    RS_ACT_LO = 2'd1,
    RS_ARM    = 2'd2,
    RS_MASK   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [CH_NUM-1:0] setCh;
    logic [CH_NUM-1:0] clrCh;
    logic [CH_NUM-1:0] tglCh;
  } strobe_t;
endpackage

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
  import cmp_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [CH_NUM-1:0] regWrData,
  output logic [CH_NUM-1:0] regRdData,
  input  logic [CH_NUM-1:0] eqVec,
  output strobe_t           strobe,
  output logic [CH_NUM-1:0] pinOe,
  output logic [CH_NUM-1:0] maskOut,
  output logic [1:0]        pacFree
);
  localparam int ACT_W = 2 * CH_NUM;

  logic [ACT_W-1:0]  actReg;
  logic [CH_NUM-1:0] armReg;
  logic [CH_NUM-1:0] maskReg;
  logic [CH_NUM-1:0] setV, clrV, tglV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actReg  <= '0;
      armReg  <= '0;
      maskReg <= '0;
    end else if (regWrEn) begin
      case (regSel_e'(regAddr))
        RS_ACT_HI: actReg[ACT_W-1:CH_NUM] <= regWrData;
        RS_ACT_LO: actReg[CH_NUM-1:0]     <= regWrData;
        RS_ARM:    armReg                 <= regWrData;
        default:   maskReg                <= regWrData;
      endcase
    end
  end

  always_comb begin
    case (regSel_e'(regAddr))
      RS_ACT_HI: regRdData = actReg[ACT_W-1:CH_NUM];
      RS_ACT_LO: regRdData = actReg[CH_NUM-1:0];
      RS_ARM:    regRdData = armReg;
      default:   regRdData = maskReg;
    endcase
  end

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    act_e code;
    logic evt;
    assign code     = act_e'(actReg[2*n+1:2*n]);
    assign evt      = eqVec[n] && tickEn && armReg[n] && !maskReg[n];
    assign setV[n]  = evt && (code == ACT_SET);
    assign clrV[n]  = evt && (code == ACT_CLR);
    assign tglV[n]  = evt && (code == ACT_TGL);
    assign pinOe[n] = (code != ACT_OFF) && !maskReg[n];
  end

  assign strobe  = '{setCh: setV, clrCh: clrV, tglCh: tglV};
  assign maskOut = maskReg;

  assign pacFree[1] = !armReg[CH_NUM-1] && (actReg[ACT_W-1 -: 2] == ACT_OFF) && !maskReg[CH_NUM-1];
  assign pacFree[0] = !armReg[0] && (actReg[1:0] == ACT_OFF) && !maskReg[0];

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == RS_MASK) |=> maskOut == $past(regWrData)) else $error("mask write"); // R11
endmodule

// File: rtl/cmp_pin_dp.sv
module cmp_pin_dp
  import cmp_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      cmpWrEn,
  input  logic [$clog2(CH_NUM)-1:0] cmpSel,
  input  logic [CNT_W-1:0]          cmpData,
  input  strobe_t                   strobe,
  output logic [CNT_W-1:0]          cntVal,
  output logic [CH_NUM-1:0]         eqVec,
  output logic [CH_NUM-1:0]         pinOut
);
  logic [CNT_W-1:0] cmpReg [CH_NUM];

  always_ff @(posedge clk) begin
    if (!rstN)       cntVal <= '0;
    else if (tickEn) cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CH_NUM; i++) cmpReg[i] <= '0;
    end else if (cmpWrEn) begin
      cmpReg[cmpSel] <= cmpData;
    end
  end

  for (genvar n = 0; n < CH_NUM; n++) begin : g_lat
    assign eqVec[n] = (cntVal == cmpReg[n]);

    always_ff @(posedge clk) begin
      if (!rstN)                 pinOut[n] <= 1'b0;
      else if (strobe.setCh[n])  pinOut[n] <= 1'b1;
      else if (strobe.clrCh[n])  pinOut[n] <= 1'b0;
      else if (strobe.tglCh[n])  pinOut[n] <= !pinOut[n];
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setCh[n] |=> pinOut[n]) else $error("set"); // R7
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrCh[n] |=> !pinOut[n]) else $error("clear"); // R6
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tglCh[n] |=> pinOut[n] != $past(pinOut[n])) else $error("toggle"); // R5
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.setCh[n] || strobe.clrCh[n] || strobe.tglCh[n]) |=> $stable(pinOut[n])) else $error("hold"); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobe.setCh[n], strobe.clrCh[n], strobe.tglCh[n]})) else $error("excl"); // R4
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cntVal == $past(cntVal) + 1'b1) else $error("step"); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntVal)) else $error("hold count"); // R2
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      regWrEn,
  input  logic [1:0]                regAddr,
  input  logic [CH_NUM-1:0]         regWrData,
  output logic [CH_NUM-1:0]         regRdData,
  input  logic                      cmpWrEn,
  input  logic [$clog2(CH_NUM)-1:0] cmpSel,
  input  logic [CNT_W-1:0]          cmpData,
  output logic [CNT_W-1:0]          cntVal,
  output logic [CH_NUM-1:0]         pinOut,
  output logic [CH_NUM-1:0]         pinOe,
  output logic [CH_NUM-1:0]         maskOut,
  output logic [1:0]                pacFree
);
  strobe_t           strobe;
  logic [CH_NUM-1:0] eqVec;

  cmp_pin_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .eqVec     (eqVec),
    .strobe    (strobe),
    .pinOe     (pinOe),
    .maskOut   (maskOut),
    .pacFree   (pacFree)
  );

  cmp_pin_dp #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cmpWrEn (cmpWrEn),
    .cmpSel  (cmpSel),
    .cmpData (cmpData),
    .strobe  (strobe),
    .cntVal  (cntVal),
    .eqVec   (eqVec),
    .pinOut  (pinOut)
  );
endmodule

// File: tb/tb_cmp_pin_unit.sv
module tb_cmp_pin_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, tickEn = 1'b0, regWrEn = 1'b0, cmpWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0, regRdData, pinOut, pinOe, maskOut;
  logic [2:0]  cmpSel = '0;
  logic [15:0] cmpData = '0, cntVal;
  logic [1:0]  pacFree;

  cmp_pin_unit dut (.*);

  int nChk = 0, nFail = 0;

  // reference model state
  logic [15:0] mAct = '0;
  logic [7:0]  mArm = '0, mMask = '0, mLat = '0;
  logic [15:0] mCnt = '0;
  logic [15:0] mCmp [8] = '{default: '0};

  function automatic logic [1:0] codeOf(int n);
    return mAct[2*n+1 -: 2];
  endfunction

  function automatic logic [7:0] expOe();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) r[n] = (codeOf(n) != 2'b00) && !mMask[n];
    return r;
  endfunction

  function automatic logic [1:0] expPac();
    return {!mArm[7] && codeOf(7) == 2'b00 && !mMask[7],
            !mArm[0] && codeOf(0) == 2'b00 && !mMask[0]};
  endfunction

  function automatic logic [7:0] expRd(logic [1:0] a);
    case (a)
      2'd0: return mAct[15:8];
      2'd1: return mAct[7:0];
      2'd2: return mArm;
      default: return mMask;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, step model (event before write: R13), compare at next negedge
  task automatic cyc(logic te, logic we, logic [1:0] a, logic [7:0] d,
                     logic cwe, logic [2:0] cs, logic [15:0] cd);
    tickEn = te; regWrEn = we; regAddr = a; regWrData = d;
    cmpWrEn = cwe; cmpSel = cs; cmpData = cd;
    for (int n = 0; n < 8; n++) begin
      if (te && mArm[n] && mCnt == mCmp[n] && !mMask[n]) begin   // R4, R11
        case (codeOf(n))
          2'b01: mLat[n] = !mLat[n];   // R5
          2'b10: mLat[n] = 1'b0;       // R6
          2'b11: mLat[n] = 1'b1;       // R7
          default: ;                   // R8
        endcase
      end
    end
    if (we) begin
      case (a)
        2'd0: mAct[15:8] = d;
        2'd1: mAct[7:0]  = d;
        2'd2: mArm       = d;
        default: mMask   = d;
      endcase
    end
    if (cwe) mCmp[cs] = cd;
    if (te) mCnt = mCnt + 16'd1;
    @(negedge clk);
    chk("R2 cntVal", cntVal, mCnt);
    chk("R9 pinOut", pinOut, mLat);
    chk("R10 pinOe", pinOe, expOe());
    chk("R11 maskOut", maskOut, mMask);
    chk("R12 pacFree", pacFree, expPac());
    chk("R3 regRdData", regRdData, expRd(a));
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(1'b0, 1'b1, a, d, 1'b0, 3'd0, 16'd0); endtask
  task automatic rd(logic [1:0] a); cyc(1'b0, 1'b0, a, 8'd0, 1'b0, 3'd0, 16'd0); endtask
  task automatic tick(); cyc(1'b1, 1'b0, 2'd0, 8'd0, 1'b0, 3'd0, 16'd0); endtask
  task automatic setCmpAll(logic [15:0] v);
    for (int c = 0; c < 8; c++) cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 3'(c), v);
  endtask
  task automatic runTo(logic [15:0] v);
    while (mCnt != v) tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 cntVal", cntVal, 16'd0);
    chk("R1 pinOut", pinOut, 8'd0);
    chk("R1 pinOe", pinOe, 8'd0);
    chk("R1 maskOut", maskOut, 8'd0);
    chk("R1 pacFree", pacFree, 2'b11);
    chk("R1 regRdData", regRdData, 8'd0);

    repeat (3) tick();
    repeat (2) rd(2'd0);
    chk("R2 count holds at 3", cntVal, 16'd3);

    wr(2'd2, 8'hFF);
    wr(2'd0, 8'hE4);   // ch7 set, ch6 clr, ch5 tgl, ch4 off
    wr(2'd1, 8'h1B);   // ch3 off, ch2 tgl, ch1 clr, ch0 set
    rd(2'd0);
    chk("R3 read action hi", regRdData, 8'hE4);
    rd(2'd1);
    chk("R3 read action lo", regRdData, 8'h1B);
    chk("R10 pinOe codes", pinOe, 8'hE7);

    setCmpAll(16'd20); runTo(16'd20); tick();
    chk("R4 R5 R7 R8 first event", pinOut, 8'hA5);
    repeat (5) tick();
    chk("R9 latch holds", pinOut, 8'hA5);

    setCmpAll(16'd40); runTo(16'd40); tick();
    chk("R5 toggle back", pinOut, 8'h81);

    wr(2'd0, 8'hFF);
    setCmpAll(16'd60); runTo(16'd60); tick();
    chk("R7 all set", pinOut, 8'hF5);

    wr(2'd0, 8'hAA);
    setCmpAll(16'd80); runTo(16'd80); tick();
    chk("R6 all clear", pinOut, 8'h01);

    wr(2'd3, 8'h01);
    wr(2'd1, 8'h1A);
    chk("R11 maskOut", maskOut, 8'h01);
    chk("R10 pinOe masked", pinOe, 8'hF6);
    setCmpAll(16'd100); runTo(16'd100); tick();
    chk("R11 masked latch kept", pinOut, 8'h05);

    wr(2'd3, 8'h00);
    setCmpAll(16'd120); runTo(16'd120);
    cyc(1'b1, 1'b1, 2'd1, 8'h1B, 1'b0, 3'd0, 16'd0);
    chk("R13 old code used", pinOut, 8'h00);
    setCmpAll(16'd140); runTo(16'd140);
    cyc(1'b1, 1'b0, 2'd0, 8'd0, 1'b1, 3'd2, 16'd500);
    chk("R13 old compare used", pinOut, 8'h05);

    wr(2'd2, 8'h7E); wr(2'd0, 8'h3F); wr(2'd1, 8'hFC);
    chk("R12 both free", pacFree, 2'b11);
    wr(2'd3, 8'h80);
    chk("R12 ch7 masked", pacFree, 2'b01);
    wr(2'd3, 8'h00); wr(2'd2, 8'hFF);
    chk("R12 armed", pacFree, 2'b00);

    runTo(16'hFFFF); tick();
    chk("R2 wrap to zero", cntVal, 16'd0);

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0, 2'($urandom), 8'($urandom),
          ($urandom % 4) == 0, 3'($urandom), mCnt + 16'($urandom % 12));
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule